// File: doc/BRIEF.md
# Pipeline Performance Counter Bank

This block watches an in-order issue stage that can send up to four instructions per cycle. It gathers that activity into three event counters. The issue stage reports each cycle how many instructions are valid, how many issued, and how the issued ones divide among seven classes: integer, floating point, load, store, subroutine call/return, conditional branch and other flow change. Single-cycle pulses come from the rest of the core: traps, mispredicts, cache and TLB misses, merged loads and buffer-full replays. A stall-active level is also supplied.

Each counter has its own event selector. The first counter either counts clock cycles or counts issued instructions. The second counter classifies cycles by how wide the issue was, or counts instructions of one class. The third counter counts miss and trap pulses, or counts stalls that last longer than a threshold.

One code of the second counter changes its meaning with the setting of the third counter. This lets a mispredict count be paired with the matching population of instructions.

Software reads all three counters directly. A single write port loads a new value into any one counter; writing zero clears it.

Top module: `perf_counter_bank`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, all three counters hold zero.
- R2: With `sel0`=0, `count0` adds 1 every cycle. With `sel0`=1, it adds `issue_cnt`.
- R3: `count1` cycle classes. Code 0 counts cycles with `valid_cnt`>0 and `issue_cnt`=0. Code 1 counts cycles with 0<`issue_cnt`<`valid_cnt`. Code 2 counts cycles with `valid_cnt`=0; such a cycle never counts under code 0. The issue stage must never present `issue_cnt`>`valid_cnt`.
- R4: `count1` codes 4, 5, 6 and 7 add 1 in cycles where `issue_cnt` equals 1, 2, 3 and 4 respectively.
- R5: `count1` code 3 adds 1 per `replay_trap` pulse. Codes 9, 10, 11 and 12 add `int_cnt`, `fp_cnt`, `ld_cnt` and `st_cnt`. Codes 13 and 14 add 1 per `icache_issue` and `dcache_access` pulse.
- R6: `count1` code 8 adds `jsr_cnt` when `sel2`=2. It adds `cbr_cnt` when `sel2`=3. For any other `sel2` it adds `jsr_cnt`+`cbr_cnt`+`oflow_cnt`.
- R7: `count2` adds 1 per pulse of the selected input. The codes are 2 `pc_mispredict`, 3 `br_mispredict`, 4 `icache_miss`, 5 `itlb_miss`, 6 `dcache_ld_miss`, 7 `dtlb_miss`, 8 `load_merged`, 9 `ld_unit_replay` and 10 `wbuf_full_replay`.
- R8: With `sel2`=0, `count2` adds 1 exactly once per stall. The increment happens on the cycle in which `stall_active` has been high for STALL_LIMIT+1 (16) consecutive cycles. The run length restarts whenever `stall_active` drops.
- R9: Reserved codes leave their counter unchanged. These are `sel1`=15, `sel2`=1 and `sel2`=11 to 15.
- R10: When `wr_en` is high, the counter chosen by `wr_idx` (0, 1 or 2) takes `wr_data` on the next edge. This happens even if an event would have incremented it that cycle.
- R11: Counters are CNT_W bits wide and wrap from all ones back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_cnt | input | 3 | Valid instructions at the issue stage (0..4) |
| issue_cnt | input | 3 | Instructions issued this cycle (0..valid_cnt) |
| int_cnt | input | 3 | Issued integer ops |
| fp_cnt | input | 3 | Issued floating-point ops |
| ld_cnt | input | 3 | Issued loads |
| st_cnt | input | 3 | Issued stores |
| jsr_cnt | input | 3 | Issued subroutine call/return |
| cbr_cnt | input | 3 | Issued conditional branches |
| oflow_cnt | input | 3 | Issued other flow-change instructions |
| replay_trap | input | 1 | Replay trap pulse |
| pc_mispredict | input | 1 | Target mispredict pulse |
| br_mispredict | input | 1 | Branch direction mispredict pulse |
| icache_miss | input | 1 | Instruction cache / refill buffer miss pulse |
| itlb_miss | input | 1 | Instruction TLB miss pulse |
| dcache_ld_miss | input | 1 | Data cache load miss pulse |
| dtlb_miss | input | 1 | Data TLB miss pulse |
| load_merged | input | 1 | Load merged into an outstanding miss pulse |
| ld_unit_replay | input | 1 | Load unit replay trap pulse |
| wbuf_full_replay | input | 1 | Write buffer / miss file full replay pulse |
| icache_issue | input | 1 | Instruction cache issue event pulse |
| dcache_access | input | 1 | Data cache access pulse |
| stall_active | input | 1 | Issue stage stalled this cycle |
| sel0 | input | 1 | Counter 0 selector |
| sel1 | input | 4 | Counter 1 selector |
| sel2 | input | 4 | Counter 2 selector |
| wr_en | input | 1 | Counter write strobe |
| wr_idx | input | 2 | Counter written (0..2) |
| wr_data | input | CNT_W | Value written |
| count0 | output | CNT_W | Counter 0 value |
| count1 | output | CNT_W | Counter 1 value |
| count2 | output | CNT_W | Counter 2 value |

## Verification
The bench builds the bank with CNT_W=16 and the default STALL_LIMIT of 15. A narrower counter lets a single preload set up the carry out of the top bit, so the wrap is seen in a few cycles. Keeping the default threshold means stall runs of exactly 15, 16 and 40 cycles hit the real boundary.

The bench sweeps every pairing of the counter 1 and counter 2 selectors under random issue mixes and pulses. This covers the three meanings of code 8 and every reserved code.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;

    // Widest issue group the stage can present in one cycle.
    localparam int ISSUE_MAX = 4;
    // Bits needed to hold 0..ISSUE_MAX.
    localparam int ISSUE_CW  = $clog2(ISSUE_MAX + 1);
    // Per-cycle increment width; a sum of three class counts fits.
    localparam int INC_W     = ISSUE_CW + 2;
    // Number of counters in the bank.
    localparam int NUM_CTR   = 3;

    typedef logic [ISSUE_CW-1:0] icount_t;
    typedef logic [INC_W-1:0]    inc_t;

    // Counter 1 selector codes. The numbering is decoded by software, so it is fixed.
    typedef enum logic [3:0] {
        C1_NONISSUE = 4'h0,
        C1_SPLIT    = 4'h1,
        C1_DRY      = 4'h2,
        C1_REPLAY   = 4'h3,
        C1_WIDE1    = 4'h4,
        C1_WIDE2    = 4'h5,
        C1_WIDE3    = 4'h6,
        C1_WIDE4    = 4'h7,
        C1_FLOW     = 4'h8,
        C1_INTOP    = 4'h9,
        C1_FPOP     = 4'hA,
        C1_LOADOP   = 4'hB,
        C1_STOREOP  = 4'hC,
        C1_ICISSUE  = 4'hD,
        C1_DCACCESS = 4'hE,
        C1_RSVD     = 4'hF
    } sel1_e;

    // Counter 2 selector codes; values 0x1 and 0xB..0xF are reserved.
    typedef enum logic [3:0] {
        C2_LONGSTALL = 4'h0,
        C2_RSVD1     = 4'h1,
        C2_PCMISS    = 4'h2,
        C2_BRMISS    = 4'h3,
        C2_ICMISS    = 4'h4,
        C2_ITBMISS   = 4'h5,
        C2_DCLDMISS  = 4'h6,
        C2_DTBMISS   = 4'h7,
        C2_LDMERGE   = 4'h8,
        C2_LDUREPLAY = 4'h9,
        C2_WBFREPLAY = 4'hA
    } sel2_e;

    // Snapshot of the issue stage for one cycle.
    typedef struct packed {
        icount_t valid;
        icount_t issued;
        icount_t n_int;
        icount_t n_fp;
        icount_t n_ld;
        icount_t n_st;
        icount_t n_jsr;
        icount_t n_cbr;
        icount_t n_oflow;
    } issue_info_t;

    // Single-cycle pulses from around the core.
    typedef struct packed {
        logic replay;
        logic pc_mp;
        logic br_mp;
        logic ic_miss;
        logic itb_miss;
        logic dc_ld_miss;
        logic dtb_miss;
        logic ld_merge;
        logic ldu_replay;
        logic wbf_replay;
        logic ic_issue;
        logic dc_access;
    } pulse_t;

    // Cycle classification produced from the issue snapshot.
    typedef struct packed {
        logic                 dry;
        logic                 none;
        logic                 split;
        logic [ISSUE_MAX-1:0] exact;  // bit k set: exactly k+1 issued
    } cyc_class_t;

    function automatic inc_t widen(input icount_t n);
        return inc_t'(n);
    endfunction

    function automatic inc_t flag(input logic b);
        return inc_t'(b);
    endfunction

endpackage

// File: rtl/perf_cycle_classify.sv
module perf_cycle_classify
    import perfctr_pkg::*;
(
    input  issue_info_t info,
    output cyc_class_t  cls
);

    logic [ISSUE_MAX-1:0] exact_w;

    // One comparator per possible issue width.
    for (genvar k = 0; k < ISSUE_MAX; k++) begin : g_width
        assign exact_w[k] = (info.issued == icount_t'(k + 1));
    end

    always_comb begin
        cls.dry   = (info.valid == '0);
        cls.none  = (info.valid != '0) && (info.issued == '0);
        cls.split = (info.issued != '0) && (info.issued < info.valid);
        cls.exact = exact_w;
    end

endmodule

// File: rtl/perf_stall_watch.sv
module perf_stall_watch #(
    parameter int STALL_LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic stall_active,
    output logic long_stall
);

    // Saturates one above the limit so a long stall reports only once.
    localparam int RUN_W = $clog2(STALL_LIMIT + 2);
    localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(STALL_LIMIT);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!stall_active) begin
            run_q <= '0;
        end else if (run_q <= LIMIT_V) begin
            run_q <= run_q + RUN_ONE;
        end
    end

    // run_q counts earlier stall cycles, so this is stall cycle LIMIT+1.
    assign long_stall = stall_active && (run_q == LIMIT_V);

endmodule

// File: rtl/perf_event_select.sv
module perf_event_select
    import perfctr_pkg::*;
(
    input  logic        sel0,
    input  logic [3:0]  sel1,
    input  logic [3:0]  sel2,
    input  issue_info_t info,
    input  cyc_class_t  cls,
    input  pulse_t      pulses,
    input  logic        long_stall,
    output inc_t        inc0,
    output inc_t        inc1,
    output inc_t        inc2
);

    inc_t flow_sel;

    // Code 8 on counter 1 narrows to the population matching counter 2.
    always_comb begin
        case (sel2)
            C2_PCMISS: flow_sel = widen(info.n_jsr);
            C2_BRMISS: flow_sel = widen(info.n_cbr);
            default:   flow_sel = widen(info.n_jsr) + widen(info.n_cbr)
                                + widen(info.n_oflow);
        endcase
    end

    always_comb begin
        inc0 = sel0 ? widen(info.issued) : flag(1'b1);
    end

    always_comb begin
        case (sel1)
            C1_NONISSUE: inc1 = flag(cls.none);
            C1_SPLIT:    inc1 = flag(cls.split);
            C1_DRY:      inc1 = flag(cls.dry);
            C1_REPLAY:   inc1 = flag(pulses.replay);
            C1_WIDE1:    inc1 = flag(cls.exact[0]);
            C1_WIDE2:    inc1 = flag(cls.exact[1]);
            C1_WIDE3:    inc1 = flag(cls.exact[2]);
            C1_WIDE4:    inc1 = flag(cls.exact[3]);
            C1_FLOW:     inc1 = flow_sel;
            C1_INTOP:    inc1 = widen(info.n_int);
            C1_FPOP:     inc1 = widen(info.n_fp);
            C1_LOADOP:   inc1 = widen(info.n_ld);
            C1_STOREOP:  inc1 = widen(info.n_st);
            C1_ICISSUE:  inc1 = flag(pulses.ic_issue);
            C1_DCACCESS: inc1 = flag(pulses.dc_access);
            default:     inc1 = '0;
        endcase
    end

    always_comb begin
        case (sel2)
            C2_LONGSTALL: inc2 = flag(long_stall);
            C2_PCMISS:    inc2 = flag(pulses.pc_mp);
            C2_BRMISS:    inc2 = flag(pulses.br_mp);
            C2_ICMISS:    inc2 = flag(pulses.ic_miss);
            C2_ITBMISS:   inc2 = flag(pulses.itb_miss);
            C2_DCLDMISS:  inc2 = flag(pulses.dc_ld_miss);
            C2_DTBMISS:   inc2 = flag(pulses.dtb_miss);
            C2_LDMERGE:   inc2 = flag(pulses.ld_merge);
            C2_LDUREPLAY: inc2 = flag(pulses.ldu_replay);
            C2_WBFREPLAY: inc2 = flag(pulses.wbf_replay);
            default:      inc2 = '0;
        endcase
    end

endmodule

// File: rtl/perf_count_reg.sv
module perf_count_reg
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  inc_t             inc,
    output logic [CNT_W-1:0] cnt
);

    // A write replaces the value; otherwise the sum wraps modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= wr_data;
        end else begin
            cnt <= cnt + CNT_W'(inc);
        end
    end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import perfctr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int STALL_LIMIT = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ISSUE_CW-1:0] valid_cnt,
    input  logic [ISSUE_CW-1:0] issue_cnt,
    input  logic [ISSUE_CW-1:0] int_cnt,
    input  logic [ISSUE_CW-1:0] fp_cnt,
    input  logic [ISSUE_CW-1:0] ld_cnt,
    input  logic [ISSUE_CW-1:0] st_cnt,
    input  logic [ISSUE_CW-1:0] jsr_cnt,
    input  logic [ISSUE_CW-1:0] cbr_cnt,
    input  logic [ISSUE_CW-1:0] oflow_cnt,
    input  logic                replay_trap,
    input  logic                pc_mispredict,
    input  logic                br_mispredict,
    input  logic                icache_miss,
    input  logic                itlb_miss,
    input  logic                dcache_ld_miss,
    input  logic                dtlb_miss,
    input  logic                load_merged,
    input  logic                ld_unit_replay,
    input  logic                wbuf_full_replay,
    input  logic                icache_issue,
    input  logic                dcache_access,
    input  logic                stall_active,
    input  logic                sel0,
    input  logic [3:0]          sel1,
    input  logic [3:0]          sel2,
    input  logic                wr_en,
    input  logic [1:0]          wr_idx,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [CNT_W-1:0]    count0,
    output logic [CNT_W-1:0]    count1,
    output logic [CNT_W-1:0]    count2
);

    issue_info_t      info;
    pulse_t           pulses;
    cyc_class_t       cls;
    logic             long_stall;
    inc_t             inc_arr [NUM_CTR];
    logic [CNT_W-1:0] cnt_arr [NUM_CTR];

    always_comb begin
        info.valid   = valid_cnt;
        info.issued  = issue_cnt;
        info.n_int   = int_cnt;
        info.n_fp    = fp_cnt;
        info.n_ld    = ld_cnt;
        info.n_st    = st_cnt;
        info.n_jsr   = jsr_cnt;
        info.n_cbr   = cbr_cnt;
        info.n_oflow = oflow_cnt;
    end

    always_comb begin
        pulses.replay     = replay_trap;
        pulses.pc_mp      = pc_mispredict;
        pulses.br_mp      = br_mispredict;
        pulses.ic_miss    = icache_miss;
        pulses.itb_miss   = itlb_miss;
        pulses.dc_ld_miss = dcache_ld_miss;
        pulses.dtb_miss   = dtlb_miss;
        pulses.ld_merge   = load_merged;
        pulses.ldu_replay = ld_unit_replay;
        pulses.wbf_replay = wbuf_full_replay;
        pulses.ic_issue   = icache_issue;
        pulses.dc_access  = dcache_access;
    end

    perf_cycle_classify u_classify (
        .info (info),
        .cls  (cls)
    );

    perf_stall_watch #(
        .STALL_LIMIT (STALL_LIMIT)
    ) u_stall (
        .clk          (clk),
        .rst          (rst),
        .stall_active (stall_active),
        .long_stall   (long_stall)
    );

    perf_event_select u_select (
        .sel0       (sel0),
        .sel1       (sel1),
        .sel2       (sel2),
        .info       (info),
        .cls        (cls),
        .pulses     (pulses),
        .long_stall (long_stall),
        .inc0       (inc_arr[0]),
        .inc1       (inc_arr[1]),
        .inc2       (inc_arr[2])
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        perf_count_reg #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_en && (wr_idx == 2'(k))),
            .wr_data (wr_data),
            .inc     (inc_arr[k]),
            .cnt     (cnt_arr[k])
        );
    end

    assign count0 = cnt_arr[0];
    assign count1 = cnt_arr[1];
    assign count2 = cnt_arr[2];

endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       valid_cnt,
    input logic [2:0]       issue_cnt,
    input logic             stall_active,
    input logic             sel0,
    input logic [3:0]       sel1,
    input logic [3:0]       sel2,
    input logic             wr_en,
    input logic [1:0]       wr_idx,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count0,
    input logic [CNT_W-1:0] count1,
    input logic [CNT_W-1:0] count2
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic wr0, wr1, wr2;
    assign wr0 = wr_en && (wr_idx == 2'd0);
    assign wr1 = wr_en && (wr_idx == 2'd1);
    assign wr2 = wr_en && (wr_idx == 2'd2);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count0 == '0 && count1 == '0 && count2 == '0)); // R1

    AST_CYCLE_TICK: assert property (@(posedge clk) disable iff (rst)
        (!wr0 && !sel0) |=> (count0 == $past(count0) + ONE)); // R2

    AST_ISSUE_LE_VALID: assert property (@(posedge clk) disable iff (rst)
        issue_cnt <= valid_cnt); // R3

    AST_DRY_NOT_NONISSUE: assert property (@(posedge clk) disable iff (rst)
        (sel1 == 4'h0 && valid_cnt == '0 && !wr1) |=> $stable(count1)); // R3

    AST_C2_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !wr2 |=> ((count2 - $past(count2)) <= ONE)); // R7

    AST_STALL_NEEDS_STALL: assert property (@(posedge clk) disable iff (rst)
        (sel2 == 4'h0 && !stall_active && !wr2) |=> $stable(count2)); // R8

    AST_RSVD1_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sel1 == 4'hF && !wr1) |=> $stable(count1)); // R9

    AST_RSVD2_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((sel2 == 4'h1 || sel2 >= 4'hB) && !wr2) |=> $stable(count2)); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr0 |=> (count0 == $past(wr_data))); // R10

    AST_WRITE_WINS_C1: assert property (@(posedge clk) disable iff (rst)
        wr1 |=> (count1 == $past(wr_data))); // R10

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!wr0 && !sel0 && count0 == '1) |=> (count0 == '0)); // R11

endmodule

bind perf_counter_bank perf_counter_bank_chk #(
    .CNT_W (CNT_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .valid_cnt    (valid_cnt),
    .issue_cnt    (issue_cnt),
    .stall_active (stall_active),
    .sel0         (sel0),
    .sel1         (sel1),
    .sel2         (sel2),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .count0       (count0),
    .count1       (count1),
    .count2       (count2)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;

    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [2:0] valid_cnt, issue_cnt, int_cnt, fp_cnt, ld_cnt, st_cnt;
    logic [2:0] jsr_cnt, cbr_cnt, oflow_cnt;
    logic [11:0] ev;
    logic stall_active, sel0, wr_en;
    logic [3:0] sel1, sel2;
    logic [1:0] wr_idx;
    logic [CW-1:0] wr_data, count0, count1, count2;

    perf_counter_bank #(.CNT_W(CW), .STALL_LIMIT(15)) i_perf_counter_bank (
        .clk(clk), .rst(rst), .valid_cnt(valid_cnt), .issue_cnt(issue_cnt),
        .int_cnt(int_cnt), .fp_cnt(fp_cnt), .ld_cnt(ld_cnt), .st_cnt(st_cnt),
        .jsr_cnt(jsr_cnt), .cbr_cnt(cbr_cnt), .oflow_cnt(oflow_cnt),
        .replay_trap(ev[0]), .pc_mispredict(ev[1]), .br_mispredict(ev[2]),
        .icache_miss(ev[3]), .itlb_miss(ev[4]), .dcache_ld_miss(ev[5]),
        .dtlb_miss(ev[6]), .load_merged(ev[7]), .ld_unit_replay(ev[8]),
        .wbuf_full_replay(ev[9]), .icache_issue(ev[10]), .dcache_access(ev[11]),
        .stall_active(stall_active), .sel0(sel0), .sel1(sel1), .sel2(sel2),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .count0(count0), .count1(count1), .count2(count2));

    typedef struct {
        logic [CW-1:0] e0, e1, e2;
        string t0, t1, t2;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_errors = 0;

    // Staging values, copied onto the DUT inputs at a falling edge.
    int   s_valid, s_issue;
    int   s_n[7];            // int, fp, ld, st, jsr, cbr, oflow
    bit   s_ev[12];
    bit   s_stall, s_sel0, s_wr;
    int   s_sel1, s_sel2, s_widx;
    logic [CW-1:0] s_wdata;
    string ovr = "";

    // Reference state.
    logic [CW-1:0] m0 = '0, m1 = '0, m2 = '0;
    int m_run = 0;

    task automatic chk(string tag, string nm, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    function automatic string tag1(int s);
        if (s <= 2) return "R3";
        if (s >= 4 && s <= 7) return "R4";
        if (s == 8) return "R6";
        if (s == 15) return "R9";
        return "R5";
    endfunction

    function automatic string tag2(int s);
        if (s == 0) return "R8";
        if (s == 1 || s >= 11) return "R9";
        return "R7";
    endfunction

    task automatic quiet();
        s_valid = 0; s_issue = 0;
        foreach (s_n[k]) s_n[k] = 0;
        foreach (s_ev[k]) s_ev[k] = 1'b0;
        s_stall = 1'b0; s_wr = 1'b0; s_widx = 0; s_wdata = '0;
    endtask

    task automatic rand_stim();
        s_valid = $urandom_range(0, 4);
        s_issue = $urandom_range(0, s_valid);
        foreach (s_n[k]) s_n[k] = 0;
        for (int i = 0; i < s_issue; i++) s_n[$urandom_range(0, 6)]++;
        foreach (s_ev[k]) s_ev[k] = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 11) == 0) s_stall = !s_stall;
        s_wr = 1'b0;
    endtask

    // Driver: applies staging, advances the reference, queues the expectation.
    task automatic apply();
        int inc0, inc1, inc2, flow;
        bit lng;
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        valid_cnt = 3'(s_valid); issue_cnt = 3'(s_issue);
        int_cnt = 3'(s_n[0]); fp_cnt = 3'(s_n[1]); ld_cnt = 3'(s_n[2]);
        st_cnt = 3'(s_n[3]); jsr_cnt = 3'(s_n[4]); cbr_cnt = 3'(s_n[5]);
        oflow_cnt = 3'(s_n[6]);
        foreach (s_ev[k]) ev[k] = s_ev[k];
        stall_active = s_stall; sel0 = s_sel0;
        sel1 = 4'(s_sel1); sel2 = 4'(s_sel2);
        wr_en = s_wr; wr_idx = 2'(s_widx); wr_data = s_wdata;

        if (s_stall) m_run++; else m_run = 0;
        lng = s_stall && (m_run == 16);

        inc0 = s_sel0 ? s_issue : 1;
        if (s_sel2 == 2) flow = s_n[4];
        else if (s_sel2 == 3) flow = s_n[5];
        else flow = s_n[4] + s_n[5] + s_n[6];
        case (s_sel1)
            0: inc1 = (s_valid > 0 && s_issue == 0);
            1: inc1 = (s_issue > 0 && s_issue < s_valid);
            2: inc1 = (s_valid == 0);
            3: inc1 = s_ev[0];
            4, 5, 6, 7: inc1 = (s_issue == s_sel1 - 3);
            8: inc1 = flow;
            9, 10, 11, 12: inc1 = s_n[s_sel1 - 9];
            13: inc1 = s_ev[10];
            14: inc1 = s_ev[11];
            default: inc1 = 0;
        endcase
        case (s_sel2)
            0: inc2 = lng;
            2, 3, 4, 5, 6, 7, 8, 9, 10: inc2 = s_ev[s_sel2 - 1];
            default: inc2 = 0;
        endcase

        it.t0 = "R2"; it.t1 = tag1(s_sel1); it.t2 = tag2(s_sel2);
        m0 = m0 + CW'(inc0); m1 = m1 + CW'(inc1); m2 = m2 + CW'(inc2);
        if (s_wr) begin
            if (s_widx == 0) begin m0 = s_wdata; it.t0 = "R10"; end
            if (s_widx == 1) begin m1 = s_wdata; it.t1 = "R10"; end
            if (s_widx == 2) begin m2 = s_wdata; it.t2 = "R10"; end
        end
        if (ovr != "") begin it.t0 = ovr; it.t1 = ovr; it.t2 = ovr; end
        it.e0 = m0; it.e1 = m1; it.e2 = m2;
        q.push_back(it);
    endtask

    // Monitor: compares shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.t0, "count0", count0, it.e0);
                chk(it.t1, "count1", count1, it.e1);
                chk(it.t2, "count2", count2, it.e2);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    task automatic write_ctr(int idx, logic [CW-1:0] val);
        s_wr = 1'b1; s_widx = idx; s_wdata = val;
        apply();
        s_wr = 1'b0;
    endtask

    task automatic stall_run(int len);
        quiet();
        s_stall = 1'b1;
        repeat (len) apply();
        s_stall = 1'b0;
        apply();
    endtask

    initial begin
        quiet();
        s_sel0 = 1'b0; s_sel1 = 15; s_sel2 = 1;
        valid_cnt = '0; issue_cnt = '0; int_cnt = '0; fp_cnt = '0; ld_cnt = '0;
        st_cnt = '0; jsr_cnt = '0; cbr_cnt = '0; oflow_cnt = '0; ev = '0;
        stall_active = 1'b0; sel0 = 1'b0; sel1 = 4'hF; sel2 = 4'h1;
        wr_en = 1'b1; wr_idx = 2'd0; wr_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        // R1: reset overrides writes and events.
        chk("R1", "count0", count0, '0);
        chk("R1", "count1", count1, '0);
        chk("R1", "count2", count2, '0);

        // Every selector pairing under random traffic.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                s_sel1 = a; s_sel2 = b; s_sel0 = ((a + b) % 2) == 1;
                rand_stim(); write_ctr(0, '0);
                rand_stim(); write_ctr(1, '0);
                rand_stim(); write_ctr(2, '0);
                repeat (18) begin rand_stim(); apply(); end
            end
        end

        // R8: stall runs around the 16-cycle threshold.
        s_sel0 = 1'b0; s_sel1 = 2; s_sel2 = 0;
        quiet(); apply();
        stall_run(15);
        stall_run(16);
        stall_run(40);
        stall_run(17);

        // R3: idle pipe counts as dry, never as non-issue.
        s_sel1 = 0; quiet(); repeat (4) apply();
        s_sel1 = 2; quiet(); repeat (4) apply();

        // R10: write collides with active increments.
        s_sel0 = 1'b1; s_sel1 = 9; s_sel2 = 2;
        rand_stim(); s_issue = s_valid; s_n[0] = s_issue; s_ev[1] = 1'b1;
        for (int k = 0; k < 3; k++) write_ctr(k, CW'(16'h1234 + k));

        // R11: wrap from all ones.
        ovr = "R11"; s_sel0 = 1'b0; s_sel1 = 2; s_sel2 = 1;
        quiet(); write_ctr(0, '1);
        quiet(); write_ctr(1, '1);
        repeat (3) apply();
        ovr = "";

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule